// File: doc/BRIEF.md
# Predicate Compare Unit

This block keeps a file of single-bit predicate flags and carries out the compare operations that set them. A compare presents two 64-bit integer operands, each carrying a deferred-exception (NaT) flag, plus a test code, a write mode, the index of the predicate that guards it and the indices of two predicates to update. In a single clock edge the block evaluates the test and writes both destinations according to the mode. Three modes are supported:

- a plain mode, which writes the outcome and its inverse;
- an AND-accumulate mode, which can only clear;
- an OR-accumulate mode, which can only set.

A separate combinational read port lets surrounding logic look up any predicate, for example to decide whether an issued instruction's guard is true. Predicate 0 is hard-wired true.

Operand fetch and instruction decode live outside the block. A compare is presented for one cycle with `cmp_valid` high and takes effect on the following rising edge.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset every predicate reads 0, except predicate 0.
- R2: Predicate 0 always reads 1, and any compare that names it as a destination leaves it at 1.
- R3: Test codes are 0 equal, 1 not equal, 2 signed less, 3 signed less-or-equal, 4 signed greater, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned less-or-equal, 8 unsigned greater, 9 unsigned greater-or-equal. Codes 10 to 15 change no predicate.
- R4: A compare is guarded by the predicate named in `cmp_qp`, as read before the compare's own update. When that predicate is 0, neither destination changes.
- R5: In plain mode (`cmp_mode` = 0), `cmp_pd1` receives the test outcome and `cmp_pd2` receives its inverse, both visible on the read port from the cycle after the compare.
- R6: In plain mode, when either operand's NaT flag is set, both destinations are cleared whatever the test outcome.
- R7: In AND mode (`cmp_mode` = 1), both destinations are cleared when the test is false or either NaT flag is set; otherwise they are unchanged.
- R8: In OR mode (`cmp_mode` = 2), both destinations are set when the test is true and neither NaT flag is set; otherwise they are unchanged. Mode 3 changes nothing.
- R9: When both destinations name the same predicate, the value meant for `cmp_pd2` is the one kept.
- R10: The read port shows register state. In the cycle a compare is presented, it returns the value before the update. A compare issued in the next cycle is guarded by the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_op | input | 4 | Test code |
| cmp_mode | input | 2 | Write mode: 0 plain, 1 AND, 2 OR, 3 none |
| cmp_qp | input | 6 | Guarding predicate index |
| cmp_pd1 | input | 6 | First destination index |
| cmp_pd2 | input | 6 | Second destination index |
| src_a | input | 64 | First operand |
| src_a_nat | input | 1 | NaT flag of the first operand |
| src_b | input | 64 | Second operand |
| src_b_nat | input | 1 | NaT flag of the second operand |
| rd_idx | input | 6 | Read port index |
| rd_val | output | 1 | Value of predicate `rd_idx` |

## Verification
A read of a predicate and a compare that writes that same predicate can fall in the same cycle. The guard lookup of one compare and the update from the compare before it can also meet at one edge. The bench provokes the first case by pointing the read port at `cmp_pd1` while the compare is held. It expects the old value, then the new one a cycle later. For the second case it issues compares back to back, with random indices drawn from a small range so guards often name a destination just written, and a directed chain does the same on purpose. A reference model that applies updates strictly in issue order judges every read.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [3:0] {
        TST_EQ  = 4'd0,
        TST_NE  = 4'd1,
        TST_LT  = 4'd2,
        TST_LE  = 4'd3,
        TST_GT  = 4'd4,
        TST_GE  = 4'd5,
        TST_LTU = 4'd6,
        TST_LEU = 4'd7,
        TST_GTU = 4'd8,
        TST_GEU = 4'd9
    } test_e;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_AND   = 2'd1,
        MODE_OR    = 2'd2,
        MODE_NONE  = 2'd3
    } mode_e;

endpackage

// File: rtl/pcu_compare.sv
module pcu_compare #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [3:0]        op,
    output logic              hit,
    output logic              legal
);
    import pcu_pkg::*;

    logic eq, slt, sgt, ult, ugt;

    always_comb begin
        eq  = (opa == opb);
        slt = ($signed(opa) < $signed(opb));
        sgt = ($signed(opa) > $signed(opb));
        ult = (opa < opb);
        ugt = (opa > opb);
    end

    always_comb begin
        legal = 1'b1;
        hit   = 1'b0;
        case (test_e'(op))
            TST_EQ:  hit = eq;
            TST_NE:  hit = !eq;
            TST_LT:  hit = slt;
            TST_LE:  hit = slt || eq;
            TST_GT:  hit = sgt;
            TST_GE:  hit = sgt || eq;
            TST_LTU: hit = ult;
            TST_LEU: hit = ult || eq;
            TST_GTU: hit = ugt;
            TST_GEU: hit = ugt || eq;
            default: legal = 1'b0;
        endcase
    end

    // R3: exactly one ordering relation holds in each domain
    p_signed_trichotomy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({slt, eq, sgt}) == 1);
    p_unsigned_trichotomy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ult, eq, ugt}) == 1);

endmodule

// File: rtl/pcu_pred_file.sv
module pcu_pred_file #(
    parameter int NUM_PREDS = 64,
    parameter int IDX_W     = $clog2(NUM_PREDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we1,
    input  logic [IDX_W-1:0] wa1,
    input  logic             wd1,
    input  logic             we2,
    input  logic [IDX_W-1:0] wa2,
    input  logic             wd2,
    input  logic [IDX_W-1:0] ra_g,
    output logic             rd_g,
    input  logic [IDX_W-1:0] ra_x,
    output logic             rd_x
);

    typedef struct packed {
        logic [NUM_PREDS-1:0] bits;
    } pf_state_t;

    localparam pf_state_t RESET_ST = '{bits: NUM_PREDS'(1)};

    pf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NUM_PREDS; i++) begin
            if (we1 && (wa1 == IDX_W'(i))) st_d.bits[i] = wd1;
            if (we2 && (wa2 == IDX_W'(i))) st_d.bits[i] = wd2;
        end
        st_d.bits[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign rd_g = st_q.bits[ra_g];
    assign rd_x = st_q.bits[ra_x];

    // R5: a lone write to a real predicate lands on the next edge
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we1 && wa1 != '0 && !(we2 && wa2 == wa1)) |=> st_q.bits[$past(wa1)] == $past(wd1));
    // R9: second destination wins on a shared index
    p_pd2_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we1 && we2 && wa1 == wa2 && wa2 != '0) |=> st_q.bits[$past(wa2)] == $past(wd2));
    // R2: predicate 0 stays true
    p_zero_pinned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bits[0] == 1'b1);

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
    parameter int DATA_W    = 64,
    parameter int NUM_PREDS = 64,
    localparam int IDX_W    = $clog2(NUM_PREDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [3:0]        cmp_op,
    input  logic [1:0]        cmp_mode,
    input  logic [IDX_W-1:0]  cmp_qp,
    input  logic [IDX_W-1:0]  cmp_pd1,
    input  logic [IDX_W-1:0]  cmp_pd2,
    input  logic [DATA_W-1:0] src_a,
    input  logic              src_a_nat,
    input  logic [DATA_W-1:0] src_b,
    input  logic              src_b_nat,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_val
);
    import pcu_pkg::*;

    logic guard_val, hit, legal, nat;
    logic we1, we2, wd1, wd2;

    pcu_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .opa   (src_a),
        .opb   (src_b),
        .op    (cmp_op),
        .hit   (hit),
        .legal (legal)
    );

    pcu_pred_file #(.NUM_PREDS(NUM_PREDS), .IDX_W(IDX_W)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we1   (we1),
        .wa1   (cmp_pd1),
        .wd1   (wd1),
        .we2   (we2),
        .wa2   (cmp_pd2),
        .wd2   (wd2),
        .ra_g  (cmp_qp),
        .rd_g  (guard_val),
        .ra_x  (rd_idx),
        .rd_x  (rd_val)
    );

    assign nat = src_a_nat || src_b_nat;

    always_comb begin
        we1 = 1'b0;
        we2 = 1'b0;
        wd1 = 1'b0;
        wd2 = 1'b0;
        if (cmp_valid && guard_val && legal) begin
            case (mode_e'(cmp_mode))
                MODE_PLAIN: begin
                    we1 = 1'b1;
                    we2 = 1'b1;
                    wd1 = hit && !nat;
                    wd2 = !hit && !nat;
                end
                MODE_AND: begin
                    we1 = !hit || nat;
                    we2 = !hit || nat;
                end
                MODE_OR: begin
                    we1 = hit && !nat;
                    we2 = hit && !nat;
                    wd1 = 1'b1;
                    wd2 = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4: a false guard suppresses every write
    p_guard_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !guard_val) |-> (!we1 && !we2));
    // R6: plain mode with a NaT operand clears both destinations
    p_nat_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && guard_val && legal && cmp_mode == 2'd0 && nat)
            |-> (we1 && we2 && !wd1 && !wd2));
    // R7: AND mode only clears
    p_and_never_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'd1) |-> !((we1 && wd1) || (we2 && wd2)));
    // R8: OR mode only sets
    p_or_never_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'd2) |-> !((we1 && !wd1) || (we2 && !wd2)));

endmodule

// File: tb/pred_cmp_unit_bench.sv
`timescale 1ns/1ps
module pred_cmp_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [3:0]  cmp_op = '0;
    logic [1:0]  cmp_mode = '0;
    logic [5:0]  cmp_qp = '0, cmp_pd1 = '0, cmp_pd2 = '0, rd_idx = '0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        src_a_nat = 1'b0, src_b_nat = 1'b0;
    logic        rd_val;

    int checks = 0;
    int failures = 0;
    bit exp_p [64];
    bit done = 1'b0;

    always #4 clk = ~clk;

    pred_cmp_unit u_pred_cmp_unit (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_mode(cmp_mode), .cmp_qp(cmp_qp), .cmp_pd1(cmp_pd1), .cmp_pd2(cmp_pd2),
        .src_a(src_a), .src_a_nat(src_a_nat), .src_b(src_b), .src_b_nat(src_b_nat),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    task automatic check(input logic act, input bit exp, input string tag, input int idx);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pred %0d actual=%0b expected=%0b", tag, idx, act, exp);
        end
    endtask

    function automatic bit f_test(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        case (op)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return $signed(a) < $signed(b);
            4'd3: return $signed(a) <= $signed(b);
            4'd4: return $signed(a) > $signed(b);
            4'd5: return $signed(a) >= $signed(b);
            4'd6: return a < b;
            4'd7: return a <= b;
            4'd8: return a > b;
            4'd9: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string f_tag(input logic [3:0] op, input logic [1:0] mode,
                                    input logic [5:0] qp, input logic [5:0] d1,
                                    input logic [5:0] d2, input bit nat);
        bit g = (qp == 0) ? 1'b1 : exp_p[qp];
        if (!g) return "R4";
        if (op > 4'd9) return "R3";
        if (d1 == 0 || d2 == 0) return "R2";
        if (mode == 2'd3) return "R8";
        if (mode == 2'd0 && d1 == d2) return "R9";
        if (mode == 2'd0 && nat) return "R6";
        if (mode == 2'd0) return "R5";
        if (mode == 2'd1) return "R7";
        return "R8";
    endfunction

    function automatic logic [63:0] rand_val(input logic [63:0] other);
        case ($urandom_range(0, 4))
            0: return {$urandom(), $urandom()};
            1: return other;
            2: return 64'($urandom_range(0, 6)) - 64'd3;
            3: case ($urandom_range(0, 3))
                   0: return 64'h0;
                   1: return 64'hFFFF_FFFF_FFFF_FFFF;
                   2: return 64'h8000_0000_0000_0000;
                   default: return 64'h7FFF_FFFF_FFFF_FFFF;
               endcase
            default: return other + 64'd1;
        endcase
    endfunction

    task automatic do_cmp(input logic [3:0] op, input logic [1:0] mode,
                          input logic [5:0] qp, input logic [5:0] d1, input logic [5:0] d2,
                          input logic [63:0] a, input bit an,
                          input logic [63:0] b, input bit bn, input string tag_in);
        bit g, hit, nat, wr, v1, v2;
        string tag;
        logic [5:0] other;
        tag = (tag_in == "") ? f_tag(op, mode, qp, d1, d2, an || bn) : tag_in;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_op = op; cmp_mode = mode; cmp_qp = qp;
        cmp_pd1 = d1; cmp_pd2 = d2; src_a = a; src_a_nat = an; src_b = b; src_b_nat = bn;
        rd_idx = d1;
        #1 check(rd_val, exp_p[d1], "R10", d1);   // old value while write pending
        g   = (qp == 0) ? 1'b1 : exp_p[qp];
        hit = f_test(op, a, b);
        nat = an || bn;
        wr = 1'b0; v1 = 1'b0; v2 = 1'b0;
        if (g && op <= 4'd9) begin
            case (mode)
                2'd0: begin wr = 1'b1; v1 = hit && !nat; v2 = !hit && !nat; end
                2'd1: if (!hit || nat) begin wr = 1'b1; v1 = 1'b0; v2 = 1'b0; end
                2'd2: if (hit && !nat) begin wr = 1'b1; v1 = 1'b1; v2 = 1'b1; end
                default: ;
            endcase
        end
        if (wr) begin
            if (d1 != 0) exp_p[d1] = v1;
            if (d2 != 0) exp_p[d2] = v2;
        end
        @(negedge clk);
        cmp_valid = 1'b0;
        rd_idx = d1; #1 check(rd_val, exp_p[d1], tag, d1);
        rd_idx = d2; #1 check(rd_val, exp_p[d2], tag, d2);
        other = 6'($urandom_range(0, 63));
        rd_idx = other; #1 check(rd_val, exp_p[other], tag, other);
    endtask

    task automatic scan_all(input string tag);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            rd_idx = 6'(i);
            #1 check(rd_val, exp_p[i], tag, i);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) exp_p[i] = 1'b0;
        exp_p[0] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 and R2: reset contents
        scan_all("R1");

        // R5: plain compare writes outcome and inverse
        do_cmp(4'd0, 2'd0, 6'd0, 6'd5, 6'd6, 64'd7, 1'b0, 64'd7, 1'b0, "R5");
        // R10: next compare guarded by p5 just written
        do_cmp(4'd2, 2'd0, 6'd5, 6'd7, 6'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd1, 1'b0, "R10");
        // R4: guard p6 is false -> no change on p7/p8
        do_cmp(4'd1, 2'd0, 6'd6, 6'd7, 6'd8, 64'd1, 1'b0, 64'd1, 1'b0, "R4");
        // R3: unsigned view of negative operand
        do_cmp(4'd6, 2'd0, 6'd0, 6'd9, 6'd10, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd1, 1'b0, "R3");
        // R3: reserved code changes nothing
        do_cmp(4'd12, 2'd0, 6'd0, 6'd5, 6'd6, 64'd0, 1'b0, 64'd0, 1'b0, "R3");
        // R6: NaT clears both in plain mode
        do_cmp(4'd0, 2'd0, 6'd0, 6'd5, 6'd6, 64'd3, 1'b0, 64'd3, 1'b1, "R6");
        // R2: write to predicate 0 ignored
        do_cmp(4'd1, 2'd0, 6'd0, 6'd0, 6'd11, 64'd3, 1'b0, 64'd3, 1'b0, "R2");
        // R9: shared destination keeps inverse
        do_cmp(4'd0, 2'd0, 6'd0, 6'd12, 6'd12, 64'd4, 1'b0, 64'd4, 1'b0, "R9");
        // R8: OR sets, then true-with-NaT and mode 3 leave unchanged
        do_cmp(4'd4, 2'd2, 6'd0, 6'd13, 6'd14, 64'd9, 1'b0, 64'd2, 1'b0, "R8");
        do_cmp(4'd4, 2'd2, 6'd0, 6'd15, 6'd16, 64'd9, 1'b1, 64'd2, 1'b0, "R8");
        do_cmp(4'd0, 2'd3, 6'd0, 6'd13, 6'd14, 64'd1, 1'b0, 64'd2, 1'b0, "R8");
        // R7: AND clears on false, holds on true
        do_cmp(4'd9, 2'd1, 6'd0, 6'd13, 6'd20, 64'd5, 1'b0, 64'd5, 1'b0, "R7");
        do_cmp(4'd2, 2'd1, 6'd0, 6'd13, 6'd14, 64'd5, 1'b0, 64'd5, 1'b0, "R7");

        for (int n = 0; n < 1500; n++) begin
            logic [63:0] a, b;
            logic [5:0] q, d1, d2;
            a  = {$urandom(), $urandom()};
            b  = rand_val(a);
            q  = ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom_range(0, 7));
            d1 = 6'($urandom_range(0, 9));
            d2 = ($urandom_range(0, 7) == 0) ? d1 : 6'($urandom_range(0, 9));
            do_cmp(($urandom_range(0, 9) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9)),
                   2'($urandom_range(0, 3)), q, d1, d2,
                   a, ($urandom_range(0, 9) == 0), b, ($urandom_range(0, 9) == 0), "");
        end

        scan_all("R2");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule